// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache with Word-Granular Dirty Tracking

This block sits between a processor that performs single-word loads and stores and a memory port that can return four consecutive words in one burst. Lines are four words long. A miss brings the whole line in with one burst read. Before that, the cache writes back the words of the victim line that carry a set dirty bit, one word at a time. Clean words of the victim are never written.

A mode input turns caching off at run time. While caching is off, every processor access becomes one single-word memory operation. When caching is turned back on, every line is invalidated, so nothing stale from before the switch is ever served. The processor sees only single-word operations, whichever mode is active.

Top module: `wordmask_cache`

## Requirements
- R1: While reset is held, `cpu_ready` and `mem_req` are low. After reset, the cache starts in the uncached mode with every line invalid.
- R2: A read that misses on a line with no dirty words issues exactly one memory request with `mem_burst`=1 and `mem_we`=0 at the line-aligned word address. The four returned beats are taken in ascending word order. The read then returns the addressed word, with no memory write.
- R3: A read or write hit completes in the cycle it is presented (`cpu_ready`=1) with no memory request in that cycle. A write hit marks only that word dirty.
- R4: On a miss to a valid line, each dirty word of the victim is written to memory (`mem_we`=1, `mem_burst`=0) at its own address, built from the victim tag, index and word offset. Clean words are not written. All write-backs finish before the fill burst is requested.
- R5: A write miss first fills the line with a burst, then merges the written word, so the other three words of the line hold memory's contents.
- R6: `cpu_ready` stays low through every write-back and fill cycle.
- R7: While caching is off, a write is one single-word memory write. A read is one single-word memory read (`mem_burst`=0), and it returns the word from `mem_rdata` when `mem_rvalid` is high.
- R8: A change of `cache_en` seen while idle takes one cycle, during which no request completes. A change from off to on invalidates every line and clears every dirty bit.
- R9: Once raised, `mem_req` stays high with `mem_addr` and `mem_we` unchanged until the cycle in which `mem_ack` is high.
- R10: The line index is word-address bits [IDX_W+1:2], and the tag is the bits above them. The last index (all ones) behaves like any other line. A burst is always a read at an address whose two low bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 = caching on, 0 = every access goes to memory |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Request completes in this cycle |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = single-word write, 0 = read |
| mem_burst | output | 1 | 1 = four-word read burst, 0 = single word |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | One read beat is on `mem_rdata` |
| mem_rdata | input | DATA_W | Read beat data |

## Verification
Two events can land in the same cycle: a processor request arriving in the very cycle that `cache_en` switches from off to on, and the invalidation that switch causes. The bench first changes a word in memory through the uncached path while an older copy of that word's line is still resident. It then raises `cache_en` on the same edge as a read of that word. The design is judged correct if that read costs a full burst fill and returns the newly written value, not the stale cached one. A line left valid, or a request served in the switch cycle, would show up as a missing fill or a wrong word.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
    localparam int WORDS_PER_LINE = 4;
    localparam int OFF_W          = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FREQ,
        ST_FDATA,
        ST_BYP,
        ST_BYPRD
    } ctl_st_e;
endpackage

// File: rtl/wmc_store.sv
module wmc_store
    import wmc_pkg::*;
#(
    parameter int LINES  = 256,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [IDX_W-1:0]                         idx,
    output logic [WORDS_PER_LINE-1:0][DATA_W-1:0]    line_o,
    output logic [TAG_W-1:0]                         tag_o,
    output logic                                     valid_o,
    output logic [WORDS_PER_LINE-1:0]                dirty_o,
    input  logic                                     wr_en,
    input  logic [OFF_W-1:0]                         wr_word,
    input  logic [DATA_W-1:0]                        wr_data,
    input  logic                                     wr_dirty,
    input  logic                                     clr_en,
    input  logic [OFF_W-1:0]                         clr_word,
    input  logic                                     tag_wr,
    input  logic [TAG_W-1:0]                         tag_val,
    input  logic                                     valid_val,
    input  logic                                     inval
);
    logic [WORDS_PER_LINE-1:0][DATA_W-1:0] data_q  [LINES];
    logic [TAG_W-1:0]                      tag_q   [LINES];
    logic [LINES-1:0]                      valid_q;
    logic [WORDS_PER_LINE-1:0]             dirty_q [LINES];

    assign line_o  = data_q[idx];
    assign tag_o   = tag_q[idx];
    assign valid_o = valid_q[idx];
    assign dirty_o = dirty_q[idx];

    always_ff @(posedge clk) begin
        if (wr_en) data_q[idx][wr_word] <= wr_data;
        if (tag_wr) tag_q[idx] <= tag_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || inval) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) dirty_q[i] <= '0;
        end else begin
            if (tag_wr) valid_q[idx] <= valid_val;
            if (wr_en)  dirty_q[idx][wr_word] <= wr_dirty;
            if (clr_en) dirty_q[idx][clr_word] <= 1'b0;
        end
    end
endmodule

// File: rtl/wmc_ctrl.sv
module wmc_ctrl
    import wmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINES  = 256,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cache_en,
    input  logic                                  cpu_req,
    input  logic                                  cpu_we,
    input  logic [ADDR_W-1:0]                     cpu_addr,
    input  logic [DATA_W-1:0]                     cpu_wdata,
    output logic [DATA_W-1:0]                     cpu_rdata,
    output logic                                  cpu_ready,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic                                  mem_burst,
    output logic [ADDR_W-1:0]                     mem_addr,
    output logic [DATA_W-1:0]                     mem_wdata,
    input  logic                                  mem_ack,
    input  logic                                  mem_rvalid,
    input  logic [DATA_W-1:0]                     mem_rdata,
    output logic [IDX_W-1:0]                      idx,
    input  logic [WORDS_PER_LINE-1:0][DATA_W-1:0] line_i,
    input  logic [TAG_W-1:0]                      tag_i,
    input  logic                                  valid_i,
    input  logic [WORDS_PER_LINE-1:0]             dirty_i,
    output logic                                  wr_en,
    output logic [OFF_W-1:0]                      wr_word,
    output logic [DATA_W-1:0]                     wr_data,
    output logic                                  wr_dirty,
    output logic                                  clr_en,
    output logic [OFF_W-1:0]                      clr_word,
    output logic                                  tag_wr,
    output logic [TAG_W-1:0]                      tag_val,
    output logic                                  valid_val,
    output logic                                  inval,
    output logic                                  mode_on,
    output logic                                  refill_busy
);
    typedef struct packed {
        ctl_st_e          st;
        logic [OFF_W-1:0] cnt;
        logic             en;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [OFF_W-1:0] off;
    logic [TAG_W-1:0] cpu_tag;
    logic             hit;

    assign off     = cpu_addr[OFF_W-1:0];
    assign idx     = cpu_addr[OFF_W+IDX_W-1:OFF_W];
    assign cpu_tag = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
    assign hit     = valid_i && (tag_i == cpu_tag);
    assign tag_val = cpu_tag;
    assign mode_on = r_q.en;
    assign refill_busy = (r_q.st == ST_WBACK) || (r_q.st == ST_FREQ) || (r_q.st == ST_FDATA);
    assign cpu_rdata   = (r_q.st == ST_BYPRD) ? mem_rdata : line_i[off];

    always_comb begin
        r_d       = r_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        wr_en     = 1'b0;
        wr_word   = off;
        wr_data   = cpu_wdata;
        wr_dirty  = 1'b0;
        clr_en    = 1'b0;
        clr_word  = r_q.cnt;
        tag_wr    = 1'b0;
        valid_val = 1'b0;
        inval     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cache_en != r_q.en) begin
                    r_d.en = cache_en;
                    inval  = cache_en;
                end else if (cpu_req) begin
                    if (!r_q.en) begin
                        r_d.st = ST_BYP;
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                        wr_en     = cpu_we;
                        wr_dirty  = 1'b1;
                    end else if (valid_i && (|dirty_i)) begin
                        r_d.st  = ST_WBACK;
                        r_d.cnt = '0;
                    end else begin
                        r_d.st = ST_FREQ;
                        tag_wr = 1'b1;
                    end
                end
            end
            ST_WBACK: begin
                mem_addr  = {tag_i, idx, r_q.cnt};
                mem_wdata = line_i[r_q.cnt];
                mem_req   = dirty_i[r_q.cnt];
                mem_we    = 1'b1;
                if (!dirty_i[r_q.cnt] || mem_ack) begin
                    clr_en  = dirty_i[r_q.cnt];
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (&r_q.cnt) begin
                        r_d.st = ST_FREQ;
                        tag_wr = 1'b1;
                    end
                end
            end
            ST_FREQ: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {cpu_tag, idx, {OFF_W{1'b0}}};
                if (mem_ack) begin
                    r_d.st  = ST_FDATA;
                    r_d.cnt = '0;
                end
            end
            ST_FDATA: begin
                if (mem_rvalid) begin
                    wr_en   = 1'b1;
                    wr_word = r_q.cnt;
                    wr_data = mem_rdata;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (&r_q.cnt) begin
                        tag_wr    = 1'b1;
                        valid_val = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            ST_BYP: begin
                mem_req = 1'b1;
                mem_we  = cpu_we;
                if (mem_ack) begin
                    cpu_ready = cpu_we;
                    r_d.st    = cpu_we ? ST_IDLE : ST_BYPRD;
                end
            end
            ST_BYPRD: begin
                if (mem_rvalid) begin
                    cpu_ready = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cnt: '0, en: 1'b0};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/wordmask_cache.sv
module wordmask_cache
    import wmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINES  = 256,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]                      idx;
    logic [WORDS_PER_LINE-1:0][DATA_W-1:0] line;
    logic [TAG_W-1:0]                      tag_rd, tag_val;
    logic                                  valid_rd, valid_val;
    logic [WORDS_PER_LINE-1:0]             dirty_rd;
    logic                                  wr_en, wr_dirty, clr_en, tag_wr, inval;
    logic [OFF_W-1:0]                      wr_word, clr_word;
    logic [DATA_W-1:0]                     wr_data;
    logic                                  mode_on, refill_busy;

    wmc_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) ctrl_i (
        .clk, .rst_n, .cache_en, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
        .cpu_rdata, .cpu_ready, .mem_req, .mem_we, .mem_burst, .mem_addr,
        .mem_wdata, .mem_ack, .mem_rvalid, .mem_rdata, .idx,
        .line_i(line), .tag_i(tag_rd), .valid_i(valid_rd), .dirty_i(dirty_rd),
        .wr_en, .wr_word, .wr_data, .wr_dirty, .clr_en, .clr_word, .tag_wr,
        .tag_val, .valid_val, .inval, .mode_on, .refill_busy
    );

    wmc_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk, .rst_n, .idx, .line_o(line), .tag_o(tag_rd), .valid_o(valid_rd),
        .dirty_o(dirty_rd), .wr_en, .wr_word, .wr_data, .wr_dirty, .clr_en,
        .clr_word, .tag_wr, .tag_val, .valid_val, .inval
    );
endmodule

// File: rtl/wmc_checker.sv
module wmc_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_burst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mode_on,
    input logic              refill_busy
);
    // R6
    no_ready_in_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_busy |-> !cpu_ready);
    // R9
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R10
    burst_is_aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_burst) |-> (!mem_we && mem_addr[1:0] == 2'b00));
    // R7
    bypass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mode_on) |-> !mem_burst);
    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && mode_on) |-> !mem_req);
    // R8
    mode_switch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_on) |-> !$past(cpu_ready));
    // R1
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);
endmodule

bind wordmask_cache wmc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk, .rst_n, .cpu_req, .cpu_ready, .mem_req, .mem_we, .mem_burst,
    .mem_addr, .mem_ack, .mode_on, .refill_busy
);

// File: tb/wordmask_cache_tb_top.sv
`timescale 1ns/1ps
module wordmask_cache_tb_top;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int MW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cache_en = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic          cpu_ready;
    logic          mem_req, mem_we, mem_burst;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0, mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #10 clk = ~clk;

    wordmask_cache #(.ADDR_W(AW), .LINES(256), .DATA_W(DW)) dut_i (
        .clk, .rst_n, .cache_en, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
        .cpu_rdata, .cpu_ready, .mem_req, .mem_we, .mem_burst, .mem_addr,
        .mem_wdata, .mem_ack, .mem_rvalid, .mem_rdata
    );

    function automatic logic [DW-1:0] seed(input int a);
        return 32'hA500_0000 ^ (a * 32'h0001_0003);
    endfunction

    logic [DW-1:0] mem  [MW];
    logic [DW-1:0] arch [MW];
    int n_wr = 0, n_fill = 0, n_single = 0;
    int rd_left = 0, rd_ptr = 0;

    // memory model: ack one cycle after a request appears, beats after acceptance
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack    <= 1'b0;
            mem_rvalid <= 1'b0;
            rd_left    = 0;
        end else begin
            mem_ack    <= 1'b0;
            mem_rvalid <= 1'b0;
            if (rd_left > 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[rd_ptr];
                rd_ptr     = rd_ptr + 1;
                rd_left    = rd_left - 1;
            end
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    n_wr++;
                end else begin
                    rd_ptr  = int'(mem_addr);
                    rd_left = mem_burst ? 4 : 1;
                    if (mem_burst) n_fill++; else n_single++;
                end
            end else if (mem_req && rd_left == 0) begin
                mem_ack <= 1'b1;
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // protocol monitors, sampled mid-cycle
    int v_ready_busy = 0, v_hold = 0, v_burst = 0;
    logic          p_pend = 1'b0;
    logic [AW-1:0] p_addr = '0;
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (cache_en && cpu_ready && (mem_req || mem_rvalid)) v_ready_busy++;
            if (p_pend && (!mem_req || mem_addr != p_addr)) v_hold++;
            if (mem_req && mem_burst && (mem_we || mem_addr[1:0] != 2'b00)) v_burst++;
            p_pend = mem_req && !mem_ack;
            p_addr = mem_addr;
        end
    end

    task automatic op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
        end
        rd = cpu_rdata;
        if (we) arch[a] = d;
        @(posedge clk);
        #1 cpu_req = 1'b0;
    endtask

    typedef struct packed {
        logic          we;
        logic [11:0]   a;
        logic [31:0]   d;
        logic [2:0]    wr;
        logic [1:0]    fl;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b0, 12'h004, 32'h0,         3'd0, 2'd1},
        '{1'b0, 12'h005, 32'h0,         3'd0, 2'd0},
        '{1'b1, 12'h006, 32'hAAAA_0006, 3'd0, 2'd0},
        '{1'b1, 12'h404, 32'hBBBB_0404, 3'd1, 2'd1},
        '{1'b0, 12'h006, 32'h0,         3'd1, 2'd1},
        '{1'b1, 12'h008, 32'hCCCC_0008, 3'd0, 2'd1},
        '{1'b1, 12'h00B, 32'hDDDD_000B, 3'd0, 2'd0},
        '{1'b1, 12'h009, 32'hEEEE_0009, 3'd0, 2'd0},
        '{1'b0, 12'h808, 32'h0,         3'd3, 2'd1},
        '{1'b0, 12'h00B, 32'h0,         3'd0, 2'd1},
        '{1'b1, 12'h3FC, 32'hFFFF_03FC, 3'd0, 2'd1},
        '{1'b0, 12'hFFC, 32'h0,         3'd1, 2'd1},
        '{1'b0, 12'h3FC, 32'h0,         3'd0, 2'd1}
    };

    bit done = 1'b0;
    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] rd;
        int w0, f0, s0;
        for (int i = 0; i < MW; i++) begin
            mem[i]  = seed(i);
            arch[i] = seed(i);
        end
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk(cpu_ready == 1'b0, "R1 ready in reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R1 mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0 && cpu_ready == 1'b0, "R1 idle after reset", mem_req, 0);

        // R2 R3 R4 R5 R10: table of accesses with expected write-back and fill counts
        for (int k = 0; k < 13; k++) begin
            w0 = n_wr; f0 = n_fill;
            op(VEC[k].we, VEC[k].a, VEC[k].d, rd);
            if (!VEC[k].we)
                chk(rd == arch[VEC[k].a], "R2 read data", rd, arch[VEC[k].a]);
            chk(n_wr - w0 == int'(VEC[k].wr), "R4 dirty write-backs", n_wr - w0, VEC[k].wr);
            chk(n_fill - f0 == int'(VEC[k].fl), "R5 R3 fill bursts", n_fill - f0, VEC[k].fl);
        end
        // R4: write-backs landed at the victim words' own addresses
        chk(mem[12'h009] == 32'hEEEE_0009, "R4 victim word placement", mem[12'h009], 32'hEEEE_0009);
        chk(mem[12'h00A] == seed(12'h00A), "R4 clean word untouched", mem[12'h00A], seed(12'h00A));

        // R7: caching off, single-word operations
        @(negedge clk); cache_en = 1'b0;
        w0 = n_wr; f0 = n_fill; s0 = n_single;
        op(1'b1, 12'h005, 32'h1234_5678, rd);
        chk(n_wr - w0 == 1 && mem[12'h005] == 32'h1234_5678, "R7 bypass write", mem[12'h005], 32'h1234_5678);
        op(1'b0, 12'h100, 32'h0, rd);
        chk(rd == seed(12'h100), "R7 bypass read data", rd, seed(12'h100));
        chk(n_single - s0 == 1 && n_fill == f0, "R7 single read no burst", n_single - s0, 1);

        // R8: re-enable in the same cycle as a read of a word cached before
        @(negedge clk);
        f0 = n_fill;
        cache_en = 1'b1; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h005;
        #1 chk(cpu_ready == 1'b0, "R8 no completion in switch cycle", cpu_ready, 0);
        forever begin
            if (cpu_ready) break;
            @(negedge clk); #1;
        end
        rd = cpu_rdata;
        @(posedge clk); #1 cpu_req = 1'b0;
        chk(rd == 32'h1234_5678, "R8 invalidated line refetched", rd, 32'h1234_5678);
        chk(n_fill - f0 == 1, "R8 fill after enable", n_fill - f0, 1);

        repeat (2) @(negedge clk);
        chk(v_ready_busy == 0, "R6 ready during memory traffic", v_ready_busy, 0);
        chk(v_hold == 0, "R9 request dropped before ack", v_hold, 0);
        chk(v_burst == 0, "R10 burst alignment", v_burst, 0);
        done = 1'b1;
        finish_run();
    end
endmodule